// File: doc/BRIEF.md
# ADC Sample Buffer with Selectable Word Width

This block holds converted analog samples until a host collects them one word at a time through a single read port. Each sample arrives with a fixed resolution set by a parameter. As it is written, it is widened to the configured storage word of 16 or 32 bits. Bipolar samples have their top bit copied into the unused upper bits. Unipolar samples get zeros there.

The storage width is chosen by an input that is captured only on reset or on a buffer clear. The host must read with an access size equal to that width. A read of the wrong size returns zero, leaves the buffer untouched and raises a sticky error. An optional completion mode marks a sample as the final one of a run. Once that sample is stored, a done flag rises and all further samples are refused until the buffer is cleared. The current fill level is always presented as a 32-bit count.

Top module: `adc_sample_fifo`

## Requirements
- R1: The word width (`wide_sel`: 0 = 16-bit words, 1 = 32-bit words) is captured when `rst` or `fifo_clear` is high. A change of `wide_sel` at any other time has no effect on stored data or on legal access size. `fifo_clear` also empties the buffer and clears `done`, `overflow`, `underflow` and `access_err`.
- R2: In 16-bit mode, a stored word appears in `rd_data[15:0]` and `rd_data[31:16]` reads as zero.
- R3: A sample with `bipolar`=1 at write time fills every bit above its resolution with its most significant bit. With `bipolar`=0 those bits are zero.
- R4: In 32-bit mode the extension of R3 covers all 32 bits of `rd_data`.
- R5: Words are read in write order. `rd_valid` and `rd_data` are presented in the cycle after the cycle in which `rd_req` is sampled.
- R6: A read whose `rd_wide` differs from the captured width returns zero and removes no entry. It sets `access_err`, which stays set until a clear.
- R7: A sample offered while `DEPTH` entries are stored is dropped and sets sticky `overflow`. The level never exceeds `DEPTH`.
- R8: A correctly sized read of an empty buffer returns zero and sets sticky `underflow`.
- R9: With `done_en`=1, an accepted sample carrying `smp_last`=1 sets `done` one cycle later. With `done_en`=0, `smp_last` has no effect.
- R10: While `done` is set, offered samples are not stored and do not set `overflow`. Reads continue to work.
- R11: `level` equals the number of stored entries and is updated one cycle after each write or read.
- R12: When `RES_BITS` is greater than 16, the 32-bit word width is used regardless of `wide_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_clear | input | 1 | Empties the buffer, clears flags, captures width |
| wide_sel | input | 1 | Word width request: 0 = 16-bit, 1 = 32-bit |
| bipolar | input | 1 | Sample is signed (sign extension) when 1 |
| done_en | input | 1 | Enables completion on the final sample |
| smp_valid | input | 1 | A sample is offered this cycle |
| smp_data | input | RES_BITS | Sample value |
| smp_last | input | 1 | Marks the final sample of a run |
| rd_req | input | 1 | Host read request |
| rd_wide | input | 1 | Host access size: 0 = 16-bit, 1 = 32-bit |
| rd_data | output | 32 | Read word, zero on illegal or empty reads |
| rd_valid | output | 1 | `rd_data` holds the result of a read |
| level | output | 32 | Stored entry count |
| done | output | 1 | Final sample stored, writes locked out |
| overflow | output | 1 | Sticky: a sample was dropped on a full buffer |
| underflow | output | 1 | Sticky: an empty buffer was read |
| access_err | output | 1 | Sticky: a read of the wrong size occurred |

## Verification
The hardest case to reach from the ports is a width change that must stay inert. The stimulus moves `wide_sel` while entries are stored, then reads them at the old size and expects the old extension. Only after a clear does the new size become legal. The done lockout is reached by marking the second of two samples as final and then offering a third. The third must leave the level unchanged and must not set `overflow`. A second instance with 20-bit resolution is held at `wide_sel`=0 through reset to show the forced 32-bit mode.

// File: rtl/adc_fifo_pkg.sv
package adc_fifo_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = 16;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/sample_extend.sv
module sample_extend
  import adc_fifo_pkg::*;
#(
  parameter int RES_BITS = 12
) (
  input  logic [RES_BITS-1:0] smp,
  input  logic                bipolar,
  input  logic                wide,
  output word_t               word
);
  word_t full;
  logic  fill_bit;

  assign fill_bit = bipolar & smp[RES_BITS-1];

  for (genvar g = 0; g < WORD_W; g++) begin : g_bit
    if (g < RES_BITS) begin : g_data
      assign full[g] = smp[g];
    end else begin : g_fill
      assign full[g] = fill_bit;
    end
  end

  assign word = wide ? full : {{(WORD_W-HALF_W){1'b0}}, full[HALF_W-1:0]};
endmodule

// File: rtl/fifo_store.sv
module fifo_store
  import adc_fifo_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr_en,
  input  word_t         wr_word,
  input  logic          rd_en,
  output word_t         rd_word,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  word_t         mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  word_t         rd_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wr_word;
    if (rd_en) rd_q <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr_en) wptr <= wptr + 1'b1;
      if (rd_en) rptr <= rptr + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rd_word = rd_q;
  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);

  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (rst)
    full |-> !wr_en);  // R7
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
    empty |-> !rd_en);  // R8
endmodule

// File: rtl/adc_sample_fifo.sv
module adc_sample_fifo
  import adc_fifo_pkg::*;
#(
  parameter int RES_BITS = 12,
  parameter int DEPTH    = 8,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fifo_clear,
  input  logic                wide_sel,
  input  logic                bipolar,
  input  logic                done_en,
  input  logic                smp_valid,
  input  logic [RES_BITS-1:0] smp_data,
  input  logic                smp_last,
  input  logic                rd_req,
  input  logic                rd_wide,
  output logic [31:0]         rd_data,
  output logic                rd_valid,
  output logic [31:0]         level,
  output logic                done,
  output logic                overflow,
  output logic                underflow,
  output logic                access_err
);
  localparam bit FORCE_WIDE = (RES_BITS > HALF_W);

  logic          act_wide;
  logic          size_ok, push, pop, full, empty, rd_zero;
  logic [CW-1:0] count;
  word_t         ext_word, mem_word;

  always_ff @(posedge clk) begin
    if (rst || fifo_clear) act_wide <= FORCE_WIDE ? 1'b1 : wide_sel;
  end

  assign size_ok = (rd_wide == act_wide);
  assign push    = smp_valid && !done && !full && !fifo_clear;
  assign pop     = rd_req && size_ok && !empty && !fifo_clear;

  sample_extend #(.RES_BITS(RES_BITS)) u_ext (
    .smp(smp_data), .bipolar(bipolar), .wide(act_wide), .word(ext_word)
  );

  fifo_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .clr(fifo_clear),
    .wr_en(push), .wr_word(ext_word),
    .rd_en(pop), .rd_word(mem_word),
    .count(count), .full(full), .empty(empty)
  );

  always_ff @(posedge clk) begin
    if (rst || fifo_clear) begin
      done       <= 1'b0;
      overflow   <= 1'b0;
      underflow  <= 1'b0;
      access_err <= 1'b0;
      rd_valid   <= 1'b0;
      rd_zero    <= 1'b1;
    end else begin
      rd_valid <= rd_req;
      rd_zero  <= !pop;
      if (rd_req && !size_ok)          access_err <= 1'b1;
      if (rd_req && size_ok && empty)  underflow  <= 1'b1;
      if (smp_valid && !done && full)  overflow   <= 1'b1;
      if (push && smp_last && done_en) done       <= 1'b1;
    end
  end

  assign rd_data = rd_zero ? '0 : mem_word;
  assign level   = {{(32-CW){1'b0}}, count};

  AST_WIDTH_HOLD: assert property (@(posedge clk) disable iff (rst)
    !fifo_clear |=> $stable(act_wide));  // R1
  AST_BADSIZE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !size_ok && !fifo_clear) |=> (rd_valid && rd_data == '0 && access_err));  // R6
  AST_BADSIZE_NOPOP: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !size_ok && !smp_valid && !fifo_clear) |=> level == $past(level));  // R6
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
    level <= 32'(DEPTH));  // R7
  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_req && empty && !fifo_clear) |=> rd_data == '0);  // R8
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(smp_valid && smp_last && done_en));  // R9
  AST_LOCKOUT: assert property (@(posedge clk) disable iff (rst)
    (done && !fifo_clear && !rd_req) |=> level == $past(level));  // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (access_err && !fifo_clear) |=> access_err);  // R6
endmodule

// File: tb/adc_sample_fifo_test.sv
module adc_sample_fifo_test;
  logic clk = 0;
  always #2 clk = ~clk;

  logic rst = 1, fifo_clear = 0, wide_sel = 0, bipolar = 0, done_en = 0;
  logic smp_valid = 0, smp_last = 0, rd_req = 0, rd_wide = 0;
  logic [11:0] smp_data = '0;
  logic [31:0] rd_data, level;
  logic rd_valid, done, overflow, underflow, access_err;

  logic w_clear = 0, w_sel = 0, w_valid = 0, w_rd = 0, w_rdw = 0;
  logic [19:0] w_data = '0;
  logic [31:0] w_rd_data, w_level;
  logic w_rd_valid, w_done, w_ovf, w_unf, w_err;

  int checks = 0, fails = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  adc_sample_fifo #(.RES_BITS(12), .DEPTH(8)) uut (
    .clk(clk), .rst(rst), .fifo_clear(fifo_clear), .wide_sel(wide_sel),
    .bipolar(bipolar), .done_en(done_en), .smp_valid(smp_valid),
    .smp_data(smp_data), .smp_last(smp_last), .rd_req(rd_req),
    .rd_wide(rd_wide), .rd_data(rd_data), .rd_valid(rd_valid),
    .level(level), .done(done), .overflow(overflow),
    .underflow(underflow), .access_err(access_err));

  adc_sample_fifo #(.RES_BITS(20), .DEPTH(4)) uut_w (
    .clk(clk), .rst(rst), .fifo_clear(w_clear), .wide_sel(w_sel),
    .bipolar(bipolar), .done_en(1'b0), .smp_valid(w_valid),
    .smp_data(w_data), .smp_last(1'b0), .rd_req(w_rd),
    .rd_wide(w_rdw), .rd_data(w_rd_data), .rd_valid(w_rd_valid),
    .level(w_level), .done(w_done), .overflow(w_ovf),
    .underflow(w_unf), .access_err(w_err));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [11:0] d, input logic last);
    smp_data = d; smp_last = last; smp_valid = 1;
    @(negedge clk);
    smp_valid = 0; smp_last = 0;
  endtask

  task automatic get(input logic wide, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    rd_wide = wide; rd_req = 1;
    @(negedge clk);
    rd_req = 0;
  endtask

  task automatic clear_buf();
    fifo_clear = 1;
    @(negedge clk);
    fifo_clear = 0;
  endtask

  // monitor: scoreboard pop on every returned read
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        chk(0, "R5 unexpected read result", rd_data, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rd_data === e, t, rd_data, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // reset state
    chk(level == 0 && !done && !overflow && !underflow && !access_err,
        "R11 reset state", {level[27:0], done, overflow, underflow, access_err}, 32'h0);

    // 16-bit mode, extension
    bipolar = 1;
    put(12'h800, 0);
    put(12'h123, 0);
    bipolar = 0;
    put(12'hABC, 0);
    chk(level == 3, "R11 level after writes", level, 32'd3);
    wide_sel = 1; // R1: no effect without clear
    @(negedge clk);
    get(0, 32'h0000F800, "R3 R2 bipolar narrow sign");
    get(0, 32'h00000123, "R2 narrow positive");
    get(0, 32'h00000ABC, "R3 R1 unipolar narrow, width held");
    chk(access_err == 0, "R1 narrow reads still legal", {31'h0, access_err}, 32'h0);
    chk(level == 0, "R11 level drained", level, 32'd0);

    // underflow
    get(0, 32'h0, "R8 empty read returns zero");
    chk(underflow == 1, "R8 underflow flag", {31'h0, underflow}, 32'h1);

    // illegal size
    put(12'h7FF, 0);
    get(1, 32'h0, "R6 wrong size returns zero");
    chk(access_err == 1, "R6 access_err set", {31'h0, access_err}, 32'h1);
    chk(level == 1, "R6 no pop", level, 32'd1);
    get(0, 32'h000007FF, "R6 entry kept");
    chk(access_err == 1, "R6 access_err sticky", {31'h0, access_err}, 32'h1);

    // clear, now 32-bit mode
    clear_buf();
    chk(level == 0 && !underflow && !access_err, "R1 clear empties and clears flags",
        {level[29:0], underflow, access_err}, 32'h0);
    bipolar = 1;
    put(12'h800, 0);
    bipolar = 0;
    put(12'hFFF, 0);
    get(1, 32'hFFFFF800, "R4 wide sign extension");
    get(1, 32'h00000FFF, "R4 R3 wide zero extension");
    chk(access_err == 0, "R1 wide legal after clear", {31'h0, access_err}, 32'h0);

    // overflow and order
    for (int i = 1; i <= 9; i++) put(12'(i), 0);
    chk(level == 8, "R7 level capped at depth", level, 32'd8);
    chk(overflow == 1, "R7 overflow flag", {31'h0, overflow}, 32'h1);
    for (int i = 1; i <= 8; i++) get(1, 32'(i), "R5 R7 order after overflow");

    // done notification and lockout
    clear_buf();
    done_en = 1;
    put(12'h011, 0);
    chk(done == 0, "R9 no done before final", {31'h0, done}, 32'h0);
    put(12'h022, 1);
    chk(done == 1, "R9 done after final sample", {31'h0, done}, 32'h1);
    put(12'h033, 0);
    chk(level == 2, "R10 write refused after done", level, 32'd2);
    chk(overflow == 0, "R10 refusal is not overflow", {31'h0, overflow}, 32'h0);
    get(1, 32'h11, "R10 reads continue");
    get(1, 32'h22, "R10 reads continue");
    clear_buf();
    chk(done == 0, "R1 clear drops done", {31'h0, done}, 32'h0);
    done_en = 0;
    put(12'h044, 1);
    chk(done == 0 && level == 1, "R9 last ignored when disabled",
        {level[30:0], done}, 32'h2);
    get(1, 32'h44, "R9 sample stored");

    // forced wide mode at 20-bit resolution
    bipolar = 1;
    w_data = 20'h80000; w_valid = 1;
    @(negedge clk);
    w_valid = 0; w_rdw = 1; w_rd = 1;
    @(negedge clk);
    w_rd = 0;
    chk(w_rd_valid && w_rd_data == 32'hFFF80000, "R12 forced 32-bit sign extension",
        w_rd_data, 32'hFFF80000);
    chk(w_err == 0, "R12 32-bit access legal", {31'h0, w_err}, 32'h0);
    bipolar = 0;

    @(negedge clk);
    chk(exp_q.size() == 0, "R5 all reads returned", 32'(exp_q.size()), 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule